// File: doc/BRIEF.md
# Phase Detector with Deferred Power-Down

This block is the digital heart of a frequency synthesizer loop. It samples two divided pulse trains, a reference train and an oscillator train, both synchronous to the system clock. It turns the lead or lag between their rising edges into up and down commands for a charge pump. When neither command is active the pump is tri-stated. When both have been latched, they are held together for a short, parameterised window before clearing. This avoids a dead zone near zero phase error.

A polarity input swaps the two commands, so loops with an inverting oscillator tuning curve can be used. An active-low sleep request stops the detector. The stop is deferred until the pump has returned to its idle, tri-stated condition, so a half-finished correction never leaves the loop frequency stepped. On leaving sleep the detector resumes on the next reference edge. A lock flag stays high while every correction pulse is short and drops low while a correction runs longer than a programmable number of clocks. Copies of the commands serve an external pump: one as a push-pull level and one as an open-drain pull-down enable. A monitor output shows one of the comparator inputs.

Top module: `pfd_pd_gate`

## Requirements
- R1: After reset, pump_up, pump_dn, pump_oe, ext_pp, ext_od_oe and sleep_o are low and lock_det is high.
- R2: With pol_sel high, a rising edge of ref_pulse (low at one clock edge, high at the next) raises pump_up after that clock edge. A rising edge of osc_pulse raises pump_dn the same way. A command stays high until cleared, and a level held high does not retrigger.
- R3: Once both commands are latched, whether from separate or coincident edges, both stay high for exactly RST_DLY clock cycles and then fall together.
- R4: With pol_sel low, the reference edge drives pump_dn and the oscillator edge drives pump_up. A change of pol_sel takes effect on the outputs without waiting for a clock edge.
- R5: pump_oe is high exactly when pump_up or pump_dn is high. ext_pp follows pump_up. ext_od_oe follows pump_dn, where high means the open-drain output pulls low.
- R6: Driving pd_req_n low while the pump is idle raises sleep_o after the second following clock edge.
- R7: If pd_req_n goes low while a command is active, sleep_o stays low until the commands have cleared. It rises one clock after the first idle cycle. While sleep_o is high, both commands stay low and input edges are ignored.
- R8: After pd_req_n returns high, sleep_o stays high and oscillator edges are ignored until the next reference rising edge. After that edge sleep_o falls and the reference command is raised.
- R9: lock_det is low while the pump has been continuously active for more than lock_limit clock cycles, counting the current one, and high otherwise.
- R10: mon_out repeats the comparator input chosen by MON_SRC (1: osc_pulse, 0: ref_pulse), delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Divided reference pulse train, clock-synchronous |
| osc_pulse | input | 1 | Divided oscillator pulse train, clock-synchronous |
| pol_sel | input | 1 | 1: normal sense, 0: commands swapped (pulled high externally) |
| pd_req_n | input | 1 | Active-low sleep request (pulled high externally) |
| lock_limit | input | CNT_W | Longest correction, in clocks, still counted as locked |
| pump_up | output | 1 | Pump source command |
| pump_dn | output | 1 | Pump sink command |
| pump_oe | output | 1 | Pump drive enable; low means tri-state |
| ext_pp | output | 1 | Push-pull copy of the up command |
| ext_od_oe | output | 1 | Open-drain enable copy of the down command |
| mon_out | output | 1 | Registered copy of the selected comparator input |
| lock_det | output | 1 | Lock flag, low during over-long corrections |
| sleep_o | output | 1 | High while powered down |

## Verification
The checker watches four properties on every cycle. Both commands are never high together for longer than the reset window. Sleep is only entered from an idle pump under an active request, and the pump stays quiet during sleep. Leaving sleep always coincides with a freshly raised command. A low lock flag always follows an active run of at least the threshold. The directed scenarios are needed for the rest: the exact edge-to-output latency, the polarity swap including its unclocked path, edges ignored while asleep or waking, the deferred entry when a correction is in flight, and the monitor delay.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   typedef enum logic [1:0] {
      PW_RUN   = 2'd0,
      PW_DRAIN = 2'd1,
      PW_OFF   = 2'd2,
      PW_WAKE  = 2'd3
   } pwr_state_t;
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
   parameter int MON_SRC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   input  logic osc_in,
   output logic ref_rise,
   output logic osc_rise,
   output logic mon
);
   logic ref_d, osc_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_d <= 1'b0;
         osc_d <= 1'b0;
      end else begin
         ref_d <= ref_in;
         osc_d <= osc_in;
      end
   end

   assign ref_rise = ref_in & ~ref_d;
   assign osc_rise = osc_in & ~osc_d;

   generate
      if (MON_SRC == 1) begin : g_mon_osc
         assign mon = osc_d;
      end else begin : g_mon_ref
         assign mon = ref_d;
      end
   endgenerate
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
   parameter int RST_DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_rise,
   input  logic osc_rise,
   input  logic ref_ok,
   input  logic osc_ok,
   input  logic hold,
   output logic up_q,
   output logic dn_q
);
   localparam int DLY_W = $clog2(RST_DLY + 1);
   localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(RST_DLY - 1);

   logic [DLY_W-1:0] dly_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q    <= 1'b0;
         dn_q    <= 1'b0;
         dly_cnt <= '0;
      end else if (hold) begin
         up_q    <= 1'b0;
         dn_q    <= 1'b0;
         dly_cnt <= '0;
      end else if (up_q && dn_q) begin
         if (dly_cnt == DLY_LAST) begin
            up_q    <= 1'b0;
            dn_q    <= 1'b0;
            dly_cnt <= '0;
         end else begin
            dly_cnt <= dly_cnt + 1'b1;
         end
      end else begin
         up_q <= up_q | (ref_rise & ref_ok);
         dn_q <= dn_q | (osc_rise & osc_ok);
      end
   end
endmodule

// File: rtl/pfd_pwr_seq.sv
module pfd_pwr_seq
   import pfd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pd_req_n,
   input  logic ref_rise,
   input  logic idle,
   output logic hold,
   output logic ref_ok,
   output logic osc_ok,
   output logic sleep
);
   pwr_state_t st, st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         PW_RUN:   if (!pd_req_n) st_nx = PW_DRAIN;
         PW_DRAIN: begin
            if (pd_req_n)  st_nx = PW_RUN;
            else if (idle) st_nx = PW_OFF;
         end
         PW_OFF:   if (pd_req_n) st_nx = PW_WAKE;
         PW_WAKE: begin
            if (!pd_req_n)    st_nx = PW_OFF;
            else if (ref_rise) st_nx = PW_RUN;
         end
         default:  st_nx = PW_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= PW_RUN;
      else        st <= st_nx;
   end

   assign hold   = (st == PW_OFF) || (st == PW_DRAIN && idle && !pd_req_n);
   assign osc_ok = (st != PW_WAKE);
   assign ref_ok = !(st == PW_WAKE && !pd_req_n);
   assign sleep  = (st == PW_OFF) || (st == PW_WAKE);
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [CNT_W-1:0] lock_limit,
   output logic             lock_det
);
   logic [CNT_W-1:0] act_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   act_cnt <= '0;
      else if (!active)             act_cnt <= '0;
      else if (act_cnt != '1)       act_cnt <= act_cnt + 1'b1;
   end

   assign lock_det = !(active && (act_cnt >= lock_limit));
endmodule

// File: rtl/pfd_pd_gate.sv
module pfd_pd_gate #(
   parameter int RST_DLY = 2,
   parameter int CNT_W   = 8,
   parameter int MON_SRC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_pulse,
   input  logic             osc_pulse,
   input  logic             pol_sel,
   input  logic             pd_req_n,
   input  logic [CNT_W-1:0] lock_limit,
   output logic             pump_up,
   output logic             pump_dn,
   output logic             pump_oe,
   output logic             ext_pp,
   output logic             ext_od_oe,
   output logic             mon_out,
   output logic             lock_det,
   output logic             sleep_o
);
   generate
      if (RST_DLY < 1) begin : g_bad_dly
         $error("RST_DLY must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (MON_SRC != 0 && MON_SRC != 1) begin : g_bad_mon
         $error("MON_SRC must be 0 or 1");
      end
   endgenerate

   logic ref_rise, osc_rise;
   logic up_q, dn_q;
   logic hold, ref_ok, osc_ok;
   logic idle;

   pfd_edge #(.MON_SRC(MON_SRC)) edge_i (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_pulse), .osc_in(osc_pulse),
      .ref_rise(ref_rise), .osc_rise(osc_rise), .mon(mon_out)
   );

   pfd_core #(.RST_DLY(RST_DLY)) core_i (
      .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .osc_rise(osc_rise),
      .ref_ok(ref_ok), .osc_ok(osc_ok), .hold(hold),
      .up_q(up_q), .dn_q(dn_q)
   );

   assign idle = !(up_q || dn_q);

   pfd_pwr_seq seq_i (
      .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .ref_rise(ref_rise),
      .idle(idle), .hold(hold), .ref_ok(ref_ok), .osc_ok(osc_ok),
      .sleep(sleep_o)
   );

   pfd_lock_mon #(.CNT_W(CNT_W)) lock_i (
      .clk(clk), .rst_n(rst_n), .active(!idle), .lock_limit(lock_limit),
      .lock_det(lock_det)
   );

   assign pump_up   = pol_sel ? up_q : dn_q;
   assign pump_dn   = pol_sel ? dn_q : up_q;
   assign pump_oe   = pump_up | pump_dn;
   assign ext_pp    = pump_up;
   assign ext_od_oe = pump_dn;
endmodule

// File: rtl/pfd_pd_gate_chk.sv
module pfd_pd_gate_chk #(
   parameter int RST_DLY = 2,
   parameter int CNT_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pd_req_n,
   input logic [CNT_W-1:0] lock_limit,
   input logic             pump_up,
   input logic             pump_dn,
   input logic             pump_oe,
   input logic             lock_det,
   input logic             sleep_o
);
   logic [31:0] both_run;
   logic [31:0] act_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         both_run <= '0;
         act_run  <= '0;
      end else begin
         both_run <= (pump_up && pump_dn) ? both_run + 1 : '0;
         act_run  <= (pump_up || pump_dn) ? act_run + 1 : '0;
      end
   end

   p_dead_zone_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pump_up && pump_dn) |-> (both_run < 32'(RST_DLY)));

   p_sleep_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_o) |-> $past(!pd_req_n));

   p_sleep_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_o) |-> $past(!pump_up && !pump_dn));

   p_quiet_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_o |-> (!pump_up && !pump_dn && !pump_oe));

   p_wake_on_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_o) |-> (pump_up || pump_dn));

   p_lock_low_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_det |-> (act_run >= 32'(lock_limit)));
endmodule

bind pfd_pd_gate pfd_pd_gate_chk #(.RST_DLY(RST_DLY), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .lock_limit(lock_limit),
   .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe),
   .lock_det(lock_det), .sleep_o(sleep_o)
);

// File: tb/pfd_pd_gate_tb_top.sv
`timescale 1ns/1ps
module pfd_pd_gate_tb_top;
   localparam int RST_DLY = 2;
   localparam int CNT_W   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_pulse = 1'b0, osc_pulse = 1'b0;
   logic pol_sel = 1'b1, pd_req_n = 1'b1;
   logic [CNT_W-1:0] lock_limit = 8'd10;
   logic pump_up, pump_dn, pump_oe, ext_pp, ext_od_oe, mon_out, lock_det, sleep_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pfd_pd_gate #(.RST_DLY(RST_DLY), .CNT_W(CNT_W), .MON_SRC(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .osc_pulse(osc_pulse),
      .pol_sel(pol_sel), .pd_req_n(pd_req_n), .lock_limit(lock_limit),
      .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe),
      .ext_pp(ext_pp), .ext_od_oe(ext_od_oe), .mon_out(mon_out),
      .lock_det(lock_det), .sleep_o(sleep_o)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_pump(input string req, input int up, input int dn);
      check(req, "pump_up", int'(pump_up), up);
      check(req, "pump_dn", int'(pump_dn), dn);
      check(req, "pump_oe", int'(pump_oe), (up | dn));
   endtask

   // both commands latched: expect RST_DLY cycles of both high, then idle
   task automatic expect_clear(input string req);
      for (int k = 0; k < RST_DLY; k++) begin
         tick();
         check_pump(req, 1, 1);
      end
      tick();
      check_pump(req, 0, 0);
      ref_pulse = 1'b0;
      osc_pulse = 1'b0;
      tick();
   endtask

   task automatic t_reset();
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      check_pump("R1", 0, 0);
      check("R1", "ext_pp", int'(ext_pp), 0);
      check("R1", "ext_od_oe", int'(ext_od_oe), 0);
      check("R1", "sleep_o", int'(sleep_o), 0);
      check("R1", "lock_det", int'(lock_det), 1);
   endtask

   task automatic t_basic();
      ref_pulse = 1'b1;
      tick();
      check_pump("R2", 1, 0);
      check("R5", "ext_pp", int'(ext_pp), 1);
      check("R5", "ext_od_oe", int'(ext_od_oe), 0);
      tick();
      check_pump("R2 held level", 1, 0);
      osc_pulse = 1'b1;
      expect_clear("R3");
   endtask

   task automatic t_coincident();
      ref_pulse = 1'b1;
      osc_pulse = 1'b1;
      tick();
      check_pump("R3 coincident", 1, 1);
      for (int k = 1; k < RST_DLY; k++) begin
         tick();
         check_pump("R3 coincident", 1, 1);
      end
      tick();
      check_pump("R3 coincident", 0, 0);
      ref_pulse = 1'b0;
      osc_pulse = 1'b0;
      tick();
   endtask

   task automatic t_polarity();
      pol_sel = 1'b0;
      ref_pulse = 1'b1;
      tick();
      check_pump("R4", 0, 1);
      check("R5", "ext_od_oe", int'(ext_od_oe), 1);
      check("R5", "ext_pp", int'(ext_pp), 0);
      pol_sel = 1'b1;
      #1;
      check_pump("R4 unclocked", 1, 0);
      pol_sel = 1'b0;
      #1;
      osc_pulse = 1'b1;
      expect_clear("R4");
      pol_sel = 1'b1;
   endtask

   task automatic t_lock();
      lock_limit = 8'd3;
      ref_pulse = 1'b1;
      for (int k = 1; k <= 6; k++) begin
         tick();
         check("R9", "lock_det", int'(lock_det), (k - 1 >= 3) ? 0 : 1);
      end
      osc_pulse = 1'b1;
      for (int k = 0; k < RST_DLY; k++) begin
         tick();
         check("R9 still long", "lock_det", int'(lock_det), 0);
      end
      tick();
      check("R9 idle", "lock_det", int'(lock_det), 1);
      ref_pulse = 1'b0;
      osc_pulse = 1'b0;
      tick();
      lock_limit = 8'd10;
   endtask

   task automatic t_pd_idle();
      pd_req_n = 1'b0;
      tick();
      check("R6 first edge", "sleep_o", int'(sleep_o), 0);
      tick();
      check("R6", "sleep_o", int'(sleep_o), 1);
      ref_pulse = 1'b1;
      tick();
      check_pump("R7 edge ignored asleep", 0, 0);
      osc_pulse = 1'b1;
      tick();
      check_pump("R7 edge ignored asleep", 0, 0);
      ref_pulse = 1'b0;
      osc_pulse = 1'b0;
      tick();
      pd_req_n = 1'b1;
      tick();
      check("R8 waiting", "sleep_o", int'(sleep_o), 1);
      osc_pulse = 1'b1;
      tick();
      check("R8 osc ignored", "sleep_o", int'(sleep_o), 1);
      check_pump("R8 osc ignored", 0, 0);
      osc_pulse = 1'b0;
      tick();
      ref_pulse = 1'b1;
      tick();
      check("R8 wake", "sleep_o", int'(sleep_o), 0);
      check_pump("R8 wake", 1, 0);
      osc_pulse = 1'b1;
      expect_clear("R8 resume");
   endtask

   task automatic t_pd_busy();
      ref_pulse = 1'b1;
      tick();
      pd_req_n = 1'b0;
      tick();
      check("R7 deferred", "sleep_o", int'(sleep_o), 0);
      check_pump("R7 deferred", 1, 0);
      tick();
      check("R7 deferred", "sleep_o", int'(sleep_o), 0);
      osc_pulse = 1'b1;
      for (int k = 0; k < RST_DLY; k++) begin
         tick();
         check("R7 deferred", "sleep_o", int'(sleep_o), 0);
      end
      tick();
      check_pump("R7 drained", 0, 0);
      check("R7 drained", "sleep_o", int'(sleep_o), 0);
      tick();
      check("R7 entered", "sleep_o", int'(sleep_o), 1);
      ref_pulse = 1'b0;
      osc_pulse = 1'b0;
      pd_req_n = 1'b1;
      tick();
      ref_pulse = 1'b1;
      tick();
      check("R8 wake", "sleep_o", int'(sleep_o), 0);
      osc_pulse = 1'b1;
      expect_clear("R8 resume");
   endtask

   task automatic t_monitor();
      osc_pulse = 1'b1;
      #1;
      check("R10 before edge", "mon_out", int'(mon_out), 0);
      tick();
      check("R10", "mon_out", int'(mon_out), 1);
      osc_pulse = 1'b0;
      tick();
      check("R10", "mon_out", int'(mon_out), 0);
      ref_pulse = 1'b1;
      tick();
      check("R10 ref not shown", "mon_out", int'(mon_out), 0);
      tick();
      ref_pulse = 1'b0;
      tick();
   endtask

   initial begin
      t_reset();
      t_basic();
      t_coincident();
      t_polarity();
      t_lock();
      t_pd_idle();
      t_pd_busy();
      t_monitor();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #500us;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule